// File: doc/BRIEF.md
# Serial Wire Debug Target Protocol Engine

This block is the target side of a two-wire debug link. The host supplies the clock, and a single bidirectional data line carries every bit. The line is modelled as a data input, a data output and an output enable. The engine hunts for a start bit, collects and checks an 8-bit request, and leaves the line undriven for a configurable turnaround. It then returns a 3-bit acknowledge and either sends or captures a data phase of 32 data bits plus a parity bit. Every field on the wire travels least-significant bit first.

Toward the chip, the engine drives a small register-bank interface: a bank select, a read flag, a two-bit register address, write data and a one-cycle strobe. The external register file returns read data combinationally for the presented address. It also supplies two response inputs that make the engine answer WAIT or FAULT instead of OK.

The engine samples the line on rising clock edges and updates its own output and enable on falling edges. This gives the host a full half period to sample target data.

Top module: `serial_dbg_target`

## Requirements
- R1: A request is eight line bits sampled in this order: bit 0 start (1), bit 1 bank select (0 debug bank, 1 access bank), bit 2 read flag (1 read, 0 write), bits 3 and 4 the address with bit 3 landing in `regAddr[0]`, bit 5 parity, bit 6 stop (0), bit 7 park (undriven, read as 1). The bank, read flag and address appear on `regBank`, `regRead` and `regAddr` whenever `regStrobe` is high.
- R2: The parity bit of a good request equals the XOR of bits 1 to 4. A request with wrong parity, stop bit or park bit gets no acknowledge and no strobe, and the target keeps `dataOe` low while it goes back to hunting for a start bit.
- R3: After a good request, the line is left undriven for `TURN_LEN` cycles before the first acknowledge bit is driven.
- R4: The acknowledge is three bits sent first bit first: OK is 1,0,0, WAIT is 0,1,0 and FAULT is 0,0,1. FAULT takes priority over WAIT, and both response inputs are sampled at the last turnaround edge.
- R5: After a WAIT or FAULT there is no data phase and no strobe. The line is undriven for `TURN_LEN` cycles and the target then hunts again.
- R6: On an OK read, the target captures `regRdata` on the edge that samples the last acknowledge bit and pulses `regStrobe` with `regRead` high. It then drives 32 data bits, LSB first, straight after the acknowledge, then an even parity bit (the XOR of the data), then releases the line for `TURN_LEN` cycles.
- R7: On an OK write, the line is undriven for `TURN_LEN` cycles after the acknowledge. The target then samples 32 data bits and a parity bit. If the parity matches, it pulses `regStrobe` for one cycle with `regRead` low and the word on `regWdata`.
- R8: A write whose parity bit differs from the XOR of its 32 data bits produces no strobe.
- R9: `dataOut` and `dataOe` never change at a rising clock edge.
- R10: During and right after reset, `dataOe` and `regStrobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock from the host |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | 1 | Resolved level of the data line |
| dataOut | output | 1 | Level the target drives on the data line |
| dataOe | output | 1 | Target drives the data line when high |
| rspWait | input | 1 | Register file asks for a WAIT acknowledge |
| rspFault | input | 1 | Register file asks for a FAULT acknowledge |
| regBank | output | 1 | Bank select of the current request |
| regRead | output | 1 | High for a read request |
| regAddr | output | 2 | Register address of the current request |
| regWdata | output | DATA_W | Captured write word |
| regRdata | input | DATA_W | Read word for the presented address |
| regStrobe | output | 1 | One-cycle pulse for an accepted access |

## Verification
The bench builds the engine with a 32-bit data word and a two-cycle turnaround. The longer turnaround makes the turnaround counter run through more than one state, and it checks that the acknowledge, the write data window and the end-of-read release all move by the parameter rather than by a fixed single cycle. Random and directed transactions cover both banks and all four addresses, and write-then-read pairs confirm that the words round-trip. Deliberately corrupted request parity, stop bits, write parity and response inputs push the engine down each rejection path.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_TRNA,
    ST_ACK,
    ST_TRNW,
    ST_WDATA,
    ST_RDATA,
    ST_TRNE
  } sdtStateT;

  // strobes from the control to the datapath
  typedef struct packed {
    logic capReq;
    logic latchAck;
    logic loadRd;
    logic capWr;
    logic fireWr;
    logic drvAck;
    logic drvRd;
  } sdtCtrlT;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

endpackage

// File: rtl/sdt_control.sv
module sdt_control
  import sdt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TURN_LEN = 1,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataIn,
  input  logic             reqGood,
  input  logic             ackOk,
  input  logic             isRead,
  output sdtCtrlT          ctrl,
  output logic [CNT_W-1:0] bitCnt,
  output sdtStateT         state
);

  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_LEN - 1);
  localparam logic [CNT_W-1:0] REQ_LAST  = CNT_W'(7);
  localparam logic [CNT_W-1:0] ACK_LAST  = CNT_W'(2);

  logic turnDone;
  assign turnDone = (bitCnt == TURN_LAST);

  always_comb begin
    ctrl          = '0;
    ctrl.capReq   = ((state == ST_IDLE) && dataIn) || (state == ST_REQ);
    ctrl.latchAck = (state == ST_TRNA) && turnDone;
    ctrl.loadRd   = (state == ST_ACK) && (bitCnt == ACK_LAST) && ackOk && isRead;
    ctrl.capWr    = (state == ST_WDATA);
    ctrl.fireWr   = (state == ST_WDATA) && (bitCnt == LAST_BIT);
    ctrl.drvAck   = (state == ST_ACK);
    ctrl.drvRd    = (state == ST_RDATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (dataIn) begin
          state  <= ST_REQ;
          bitCnt <= CNT_W'(1);
        end
        ST_REQ: begin
          if (bitCnt == REQ_LAST) begin
            state  <= reqGood ? ST_TRNA : ST_IDLE;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_TRNA: begin
          if (turnDone) begin
            state  <= ST_ACK;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_ACK: begin
          if (bitCnt == ACK_LAST) begin
            bitCnt <= '0;
            if (!ackOk)      state <= ST_TRNE;
            else if (isRead) state <= ST_RDATA;
            else             state <= ST_TRNW;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_TRNW: begin
          if (turnDone) begin
            state  <= ST_WDATA;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_WDATA, ST_RDATA: begin
          if (bitCnt == LAST_BIT) begin
            state  <= (state == ST_WDATA) ? ST_IDLE : ST_TRNE;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_TRNE: begin
          if (turnDone) begin
            state  <= ST_IDLE;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: begin
          state  <= ST_IDLE;
          bitCnt <= '0;
        end
      endcase
    end
  end

  // a bad request drops straight back to hunting
  assert_bad_req_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REQ && bitCnt == REQ_LAST && !reqGood) |=> (state == ST_IDLE));

  assert_ack_after_turn_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK && $past(state) != ST_ACK) |-> ($past(state) == ST_TRNA));

  assert_no_data_on_reject_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK && bitCnt == ACK_LAST && !ackOk) |=> (state == ST_TRNE));

  assert_read_follows_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RDATA && $past(state) != ST_RDATA) |-> ($past(state) == ST_ACK));

endmodule

// File: rtl/sdt_datapath.sv
module sdt_datapath
  import sdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataIn,
  input  sdtCtrlT           ctrl,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic              rspWait,
  input  logic              rspFault,
  input  logic [DATA_W-1:0] regRdata,
  output logic              reqGood,
  output logic              ackOk,
  output logic              isRead,
  output logic              regBank,
  output logic              regRead,
  output logic [1:0]        regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regStrobe,
  output logic              dataOut,
  output logic              dataOe
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  logic [6:0]        reqBits;   // start .. stop, park is taken live
  logic [2:0]        ackReg;
  logic [DATA_W-1:0] dataWord;
  logic              rdPar;
  logic              wrParOk;
  logic              ackBit;
  logic              rdBit;

  // live check on the park edge: start, stop, park and parity
  assign reqGood = reqBits[0] & ~reqBits[6] & dataIn &
                   (reqBits[5] == ^reqBits[4:1]);
  assign regBank = reqBits[1];
  assign regRead = reqBits[2];
  assign isRead  = reqBits[2];
  assign regAddr = reqBits[4:3];
  assign ackOk   = (ackReg == ACK_OK);
  assign regWdata = dataWord;
  assign wrParOk = (dataIn == ^dataWord);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqBits   <= '0;
      ackReg    <= ACK_OK;
      dataWord  <= '0;
      rdPar     <= 1'b0;
      regStrobe <= 1'b0;
    end else begin
      if (ctrl.capReq && bitCnt < CNT_W'(7))
        reqBits[bitCnt[2:0]] <= dataIn;
      if (ctrl.latchAck)
        ackReg <= rspFault ? ACK_FAULT : (rspWait ? ACK_WAIT : ACK_OK);
      if (ctrl.loadRd) begin
        dataWord <= regRdata;
        rdPar    <= ^regRdata;
      end else if (ctrl.capWr && bitCnt != LAST_BIT) begin
        dataWord[bitCnt[IDX_W-1:0]] <= dataIn;
      end
      regStrobe <= ctrl.loadRd | (ctrl.fireWr & wrParOk);
    end
  end

  always_comb begin
    unique case (bitCnt[1:0])
      2'd0:    ackBit = ackReg[0];
      2'd1:    ackBit = ackReg[1];
      default: ackBit = ackReg[2];
    endcase
    rdBit = (bitCnt == LAST_BIT) ? rdPar : dataWord[bitCnt[IDX_W-1:0]];
  end

  // line driver updates on the falling edge only
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOe  <= 1'b0;
      dataOut <= 1'b0;
    end else begin
      dataOe  <= ctrl.drvAck | ctrl.drvRd;
      dataOut <= ctrl.drvAck ? ackBit : (ctrl.drvRd ? rdBit : 1'b0);
    end
  end

  // an accepted write carries a parity bit that matched its word
  assert_write_parity_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regStrobe && !regRead) |-> ((^regWdata) == $past(dataIn)));

endmodule

// File: rtl/serial_dbg_target.sv
module serial_dbg_target
  import sdt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TURN_LEN = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataIn,
  output logic              dataOut,
  output logic              dataOe,
  input  logic              rspWait,
  input  logic              rspFault,
  output logic              regBank,
  output logic              regRead,
  output logic [1:0]        regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata,
  output logic              regStrobe
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  sdtCtrlT          ctrl;
  sdtStateT         state;
  logic [CNT_W-1:0] bitCnt;
  logic             reqGood;
  logic             ackOk;
  logic             isRead;

  sdt_control #(.DATA_W(DATA_W), .TURN_LEN(TURN_LEN), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .reqGood(reqGood),
    .ackOk(ackOk), .isRead(isRead), .ctrl(ctrl), .bitCnt(bitCnt), .state(state)
  );

  sdt_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .ctrl(ctrl), .bitCnt(bitCnt),
    .rspWait(rspWait), .rspFault(rspFault), .regRdata(regRdata),
    .reqGood(reqGood), .ackOk(ackOk), .isRead(isRead), .regBank(regBank),
    .regRead(regRead), .regAddr(regAddr), .regWdata(regWdata),
    .regStrobe(regStrobe), .dataOut(dataOut), .dataOe(dataOe)
  );

  // the driver stays off outside the acknowledge and read-data states
  assert_quiet_turn_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_ACK && state != ST_RDATA) |-> !dataOe);

endmodule

// File: tb/serial_dbg_target_tb.sv
module serial_dbg_target_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW   = 32;
  localparam int TURN = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostOe = 1'b1;
  logic          hostOut = 1'b0;
  logic          dataIn, dataOut, dataOe;
  logic          rspWait = 1'b0, rspFault = 1'b0;
  logic          regBank, regRead, regStrobe;
  logic [1:0]    regAddr;
  logic [DW-1:0] regWdata, regRdata;

  logic [DW-1:0] rfMem [8];
  logic [DW-1:0] expMem [8];
  int            strobeCnt = 0;
  logic          capBank, capRead;
  logic [1:0]    capAddr;
  logic [DW-1:0] capWdata;
  logic          edgeBad = 1'b0;
  int            checks = 0, fails = 0;
  bit            finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // host drive wins, else target, else the pull-up
  assign dataIn   = hostOe ? hostOut : (dataOe ? dataOut : 1'b1);
  assign regRdata = rfMem[{regBank, regAddr}];

  serial_dbg_target #(.DATA_W(DW), .TURN_LEN(TURN)) u_dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .rspWait(rspWait), .rspFault(rspFault), .regBank(regBank), .regRead(regRead),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .regStrobe(regStrobe)
  );

  // register file model
  always @(negedge clk) begin
    if (rstN && regStrobe) begin
      strobeCnt = strobeCnt + 1;
      capBank  = regBank;
      capRead  = regRead;
      capAddr  = regAddr;
      capWdata = regWdata;
      if (!regRead) rfMem[{regBank, regAddr}] = regWdata;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bit time: drive at the falling edge, observe mid-low, recheck after rise
  task automatic tick(input logic drv, input logic val, output logic seenOe, output logic seenOut);
    @(negedge clk);
    hostOe  = drv;
    hostOut = val;
    #(CLK_PERIOD/4);
    seenOe  = dataOe;
    seenOut = dataOut;
    @(posedge clk);
    #1;
    if (dataOe !== seenOe || (seenOe && dataOut !== seenOut)) edgeBad = 1'b1;
  endtask

  function automatic logic [2:0] expAck(input logic wt, input logic ft);
    return ft ? 3'b100 : (wt ? 3'b010 : 3'b001);
  endfunction

  // badKind: 0 good, 1 request parity wrong, 2 stop bit high
  task automatic txn(input logic bank, input logic rd, input logic [1:0] addr,
                     input logic [DW-1:0] wdat, input int badKind,
                     input logic wrBad, input logic wt, input logic ft);
    logic [7:0]    req;
    logic          so, sv;
    logic          anyOe;
    logic [2:0]    ackGot, ackExp;
    logic [DW:0]   rdGot;
    int            sc0;
    logic [2:0]    idx;
    idx = {bank, addr};
    req = 8'h00;
    req[0] = 1'b1;
    req[1] = bank;
    req[2] = rd;
    req[4:3] = addr;
    req[5] = (^{bank, rd, addr}) ^ (badKind == 1);
    req[6] = (badKind == 2);
    rspWait  = wt;
    rspFault = ft;
    sc0 = strobeCnt;
    edgeBad = 1'b0;
    for (int i = 0; i < 7; i++) tick(1'b1, req[i], so, sv);
    tick(1'b0, 1'b0, so, sv);  // park left to the pull-up
    if (badKind != 0) begin
      anyOe = 1'b0;
      for (int i = 0; i < 6; i++) begin
        tick(1'b1, 1'b0, so, sv);
        anyOe |= so;
      end
      chk("R2 no drive after bad request", anyOe, 0);
      chk("R2 no strobe after bad request", strobeCnt - sc0, 0);
      return;
    end
    anyOe = 1'b0;
    for (int i = 0; i < TURN; i++) begin
      tick(1'b0, 1'b0, so, sv);
      anyOe |= so;
    end
    chk("R3 turnaround before ack undriven", anyOe, 0);
    ackGot = '0;
    anyOe = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick(1'b0, 1'b0, so, sv);
      ackGot[i] = sv;
      anyOe &= so;
    end
    ackExp = expAck(wt, ft);
    chk("R4 ack driven", anyOe, 1);
    chk("R4 ack code", ackGot, ackExp);
    if (ackExp != 3'b001) begin
      anyOe = 1'b0;
      for (int i = 0; i < TURN + 3; i++) begin
        tick(i >= TURN, 1'b0, so, sv);
        anyOe |= so;
      end
      chk("R5 no data phase after reject", anyOe, 0);
      chk("R5 no strobe after reject", strobeCnt - sc0, 0);
    end else if (rd) begin
      anyOe = 1'b1;
      for (int i = 0; i <= DW; i++) begin
        tick(1'b0, 1'b0, so, sv);
        rdGot[i] = sv;
        anyOe &= so;
      end
      chk("R6 read data driven", anyOe, 1);
      chk("R6 read data", rdGot[DW-1:0], expMem[idx]);
      chk("R6 read parity", rdGot[DW], ^expMem[idx]);
      anyOe = 1'b0;
      for (int i = 0; i < TURN; i++) begin
        tick(1'b0, 1'b0, so, sv);
        anyOe |= so;
      end
      chk("R6 release after read", anyOe, 0);
      tick(1'b1, 1'b0, so, sv);
      tick(1'b1, 1'b0, so, sv);
      chk("R6 read strobe count", strobeCnt - sc0, 1);
      chk("R1 read fields", {capRead, capBank, capAddr}, {1'b1, bank, addr});
    end else begin
      anyOe = 1'b0;
      for (int i = 0; i < TURN; i++) begin
        tick(1'b0, 1'b0, so, sv);
        anyOe |= so;
      end
      chk("R7 turnaround after write ack", anyOe, 0);
      for (int i = 0; i < DW; i++) tick(1'b1, wdat[i], so, sv);
      tick(1'b1, (^wdat) ^ wrBad, so, sv);
      tick(1'b1, 1'b0, so, sv);
      tick(1'b1, 1'b0, so, sv);
      if (wrBad) begin
        chk("R8 bad write parity discarded", strobeCnt - sc0, 0);
      end else begin
        chk("R7 write strobe count", strobeCnt - sc0, 1);
        chk("R7 write data", capWdata, wdat);
        chk("R1 write fields", {capRead, capBank, capAddr}, {1'b0, bank, addr});
        expMem[idx] = wdat;
      end
    end
    chk("R9 outputs steady at rising edge", edgeBad, 0);
    tick(1'b1, 1'b0, so, sv);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic so, sv;
    void'($urandom(32'd7151));
    for (int i = 0; i < 8; i++) begin
      rfMem[i]  = $urandom;
      expMem[i] = rfMem[i];
    end
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset oe low", dataOe, 0);
    chk("R10 reset strobe low", regStrobe, 0);
    @(negedge clk);
    rstN = 1'b1;
    tick(1'b1, 1'b0, so, sv);
    tick(1'b1, 1'b0, so, sv);
    chk("R10 idle after reset", {dataOe, regStrobe}, 0);

    // directed corners
    txn(1'b0, 1'b1, 2'd1, '0, 0, 1'b0, 1'b0, 1'b0);            // debug bank read
    txn(1'b1, 1'b0, 2'd2, 32'hA5C3_0F96, 0, 1'b0, 1'b0, 1'b0); // access bank write
    txn(1'b1, 1'b1, 2'd2, '0, 0, 1'b0, 1'b0, 1'b0);            // read back
    txn(1'b0, 1'b0, 2'd3, 32'h1234_5678, 1, 1'b0, 1'b0, 1'b0); // bad request parity
    txn(1'b1, 1'b1, 2'd0, '0, 2, 1'b0, 1'b0, 1'b0);            // bad stop
    txn(1'b0, 1'b1, 2'd0, '0, 0, 1'b0, 1'b1, 1'b0);            // WAIT
    txn(1'b1, 1'b0, 2'd1, 32'hFFFF_FFFF, 0, 1'b0, 1'b0, 1'b1); // FAULT
    txn(1'b0, 1'b0, 2'd2, 32'h0, 0, 1'b0, 1'b1, 1'b1);         // FAULT over WAIT
    txn(1'b0, 1'b0, 2'd3, 32'hDEAD_BEEF, 0, 1'b1, 1'b0, 1'b0); // bad write parity
    txn(1'b0, 1'b1, 2'd3, '0, 0, 1'b0, 1'b0, 1'b0);            // unchanged
    txn(1'b0, 1'b0, 2'd0, 32'h8000_0001, 0, 1'b0, 1'b0, 1'b0);
    txn(1'b0, 1'b1, 2'd0, '0, 0, 1'b0, 1'b0, 1'b0);

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [7:0] r;
      int bk;
      r  = 8'($urandom);
      bk = ($urandom % 8 == 0) ? int'(1 + ($urandom % 2)) : 0;
      txn(r[0], r[1], r[3:2], $urandom, bk, ($urandom % 6) == 0,
          ($urandom % 7) == 0, ($urandom % 9) == 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule